// File: doc/BRIEF.md
# Atomic Lock Acquirer with Doubling Retry Delay

This block takes a shared one-bit lock in memory on behalf of a processor. When the processor asks for the lock, the block requests the shared bus. Once the bus is granted it reads the lock word and then writes 1 to it. It raises a bus lock line for both accesses, so no other master can reach the word between the read and the write. If the value read was 0, the processor now owns the lock. If it was 1, another agent holds the lock: the block gives up the bus, waits a number of cycles, and tries again. The wait doubles after every failed try up to a set ceiling, and it returns to one cycle after a successful take.

While the processor owns the lock an ownership output stays high. A release request from the processor makes the block win the bus again and write 0 to the word, without the bus lock line. Ownership drops once that write completes. The arbiter keeps its grant high for as long as the request stays high. A memory access completes in a cycle in which the ready input is high.

Top module: `tas_lock_agent`

## Requirements
- R1: While reset is asserted and right after it, `owned`, `bus_req`, `bus_lock` and `mem_valid` are 0.
- R2: After an acquire pulse in the idle state, `bus_req` goes high. No memory access (`mem_valid`) is issued unless `bus_gnt` is high.
- R3: A try is a read (`mem_we`=0) followed in the next access by a write of 1 (`mem_we`=1, `mem_wdata`=1). `bus_lock` is high during both, and it is low in the cycle after the write completes.
- R4: If the read returned 0, `owned` goes high in the cycle after the write completes. It stays high until the release write completes.
- R5: If the read returned 1, `owned` stays low and the block retries on its own.
- R6: After a failed try, `bus_req` stays low for exactly D cycles before the next try. D is 1 after reset and doubles after every further consecutive failure.
- R7: D never exceeds MAX_DELAY (default 16), so the sequence is 1, 2, 4, 8, 16, 16, ...
- R8: A successful acquire resets D to 1 for the next failure.
- R9: A release pulse while the lock is owned causes one write of 0 with `bus_lock` low, issued after grant. `owned` falls in the cycle after that write completes.
- R10: A release pulse while not owning, and an acquire pulse while owning, cause no bus request, no memory access and no change of `owned`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | 1 | Acquire pulse from the processor |
| rel_req | input | 1 | Release pulse from the processor |
| owned | output | 1 | The processor holds the lock |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, held while bus_req is high |
| bus_lock | output | 1 | Keeps other masters off the bus during the read and write |
| mem_valid | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | 1 | Value written to the lock word |
| mem_rdata | input | 1 | Lock word value returned by a read |
| mem_ready | input | 1 | Access completes in this cycle |

## Verification
The block is first tried with a free lock and a grant that arrives late. This shows that it waits for the bus and then wins on the first try. It is then tried against a lock that another agent holds for seven tries, which shows the doubling delays and where they stop at the ceiling. After the lock is freed and released, it is blocked again to show that the delay restarts at one. Acquire and release pulses given in the wrong state show whether stray requests leak onto the bus or change ownership.

// File: rtl/tas_pkg.sv
package tas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_READ,
    ST_WRITE,
    ST_WAIT,
    ST_OWN,
    ST_RARB,
    ST_RWRITE
  } tas_state_t;

  // Next retry delay: double the present one, clipped at the ceiling.
  function automatic int unsigned backoff_next(int unsigned cur, int unsigned cap);
    int unsigned dbl;
    dbl = cur * 2;
    return (dbl > cap) ? cap : dbl;
  endfunction

endpackage

// File: rtl/tas_backoff.sv
module tas_backoff #(
  parameter int unsigned MAX_DELAY = 16,
  localparam int DLY_W = $clog2(MAX_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic             run,
  output logic             expired,
  output logic [DLY_W-1:0] delay
);
  import tas_pkg::*;

  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay <= DLY_W'(1);
      cnt   <= '0;
    end else if (load) begin
      cnt   <= delay;
      delay <= DLY_W'(backoff_next(32'(delay), MAX_DELAY));
    end else begin
      if (clear) delay <= DLY_W'(1);
      if (run && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == DLY_W'(1));

  AST_BO_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (delay >= $past(delay)));  // R6
  AST_BO_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (delay <= DLY_W'(MAX_DELAY)) && (delay != '0));  // R7
  AST_BO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (delay == DLY_W'(1)));  // R8

endmodule

// File: rtl/tas_ctrl.sv
module tas_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_req,
  input  logic rel_req,
  input  logic bus_gnt,
  input  logic mem_ready,
  input  logic mem_rdata,
  input  logic bo_expired,
  output logic owned,
  output logic bus_req,
  output logic bus_lock,
  output logic mem_valid,
  output logic mem_we,
  output logic mem_wdata,
  output logic tas_win,
  output logic tas_lose,
  output logic bo_run
);
  import tas_pkg::*;

  tas_state_t state, state_nx;
  logic       old_val;
  logic       rd_done;
  logic       rel_done;

  assign rd_done  = (state == ST_READ)   && mem_ready;
  assign tas_win  = (state == ST_WRITE)  && mem_ready && !old_val;
  assign tas_lose = (state == ST_WRITE)  && mem_ready &&  old_val;
  assign rel_done = (state == ST_RWRITE) && mem_ready;
  assign bo_run   = (state == ST_WAIT);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (acq_req)    state_nx = ST_ARB;
      ST_ARB:    if (bus_gnt)    state_nx = ST_READ;
      ST_READ:   if (rd_done)    state_nx = ST_WRITE;
      ST_WRITE:  if (tas_win)    state_nx = ST_OWN;
                 else if (tas_lose) state_nx = ST_WAIT;
      ST_WAIT:   if (bo_expired) state_nx = ST_ARB;
      ST_OWN:    if (rel_req)    state_nx = ST_RARB;
      ST_RARB:   if (bus_gnt)    state_nx = ST_RWRITE;
      ST_RWRITE: if (rel_done)   state_nx = ST_IDLE;
      default:                   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      old_val <= 1'b0;
    end else begin
      state <= state_nx;
      if (rd_done) old_val <= mem_rdata;
    end
  end

  assign owned     = (state == ST_OWN) || (state == ST_RARB) || (state == ST_RWRITE);
  assign bus_req   = (state == ST_ARB) || (state == ST_READ) || (state == ST_WRITE) ||
                     (state == ST_RARB) || (state == ST_RWRITE);
  assign bus_lock  = (state == ST_READ) || (state == ST_WRITE);
  assign mem_valid = (state == ST_READ) || (state == ST_WRITE) || (state == ST_RWRITE);
  assign mem_we    = (state == ST_WRITE) || (state == ST_RWRITE);
  assign mem_wdata = (state == ST_WRITE);

  AST_ACCESS_HAS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_gnt);  // R2
  AST_READ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> bus_lock);  // R3
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (mem_valid && mem_we && mem_wdata && bus_lock));  // R3
  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tas_win || tas_lose) |=> !bus_lock);  // R3
  AST_WIN_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    tas_win |=> owned);  // R4
  AST_LOSE_NOT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    tas_lose |=> !owned);  // R5
  AST_RELEASE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !mem_wdata) |-> !bus_lock);  // R9
  AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done |=> !owned);  // R9

endmodule

// File: rtl/tas_lock_agent.sv
module tas_lock_agent #(
  parameter int unsigned MAX_DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_req,
  input  logic rel_req,
  output logic owned,
  output logic bus_req,
  input  logic bus_gnt,
  output logic bus_lock,
  output logic mem_valid,
  output logic mem_we,
  output logic mem_wdata,
  input  logic mem_rdata,
  input  logic mem_ready
);
  localparam int DLY_W = $clog2(MAX_DELAY + 1);

  logic             tas_win;
  logic             tas_lose;
  logic             bo_run;
  logic             bo_expired;
  logic [DLY_W-1:0] bo_delay;

  tas_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_req    (acq_req),
    .rel_req    (rel_req),
    .bus_gnt    (bus_gnt),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .bo_expired (bo_expired),
    .owned      (owned),
    .bus_req    (bus_req),
    .bus_lock   (bus_lock),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .tas_win    (tas_win),
    .tas_lose   (tas_lose),
    .bo_run     (bo_run)
  );

  tas_backoff #(.MAX_DELAY(MAX_DELAY)) u_backoff (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tas_lose),
    .clear   (tas_win),
    .run     (bo_run),
    .expired (bo_expired),
    .delay   (bo_delay)
  );

  AST_RETRY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    tas_lose |=> !bus_req);  // R6

endmodule

// File: tb/tb_tas_lock_agent.sv
module tb_tas_lock_agent;
  localparam int MAXD = 16;

  logic clk = 1'b0;
  logic rst_n, acq_req, rel_req;
  logic owned, bus_req, bus_gnt, bus_lock;
  logic mem_valid, mem_we, mem_wdata, mem_rdata, mem_ready;

  logic lock_word;
  logic other_busy, ext_set, ext_clr;

  int errors = 0, checks = 0;
  int acc_cnt = 0, req_cnt = 0, fail_cnt = 0, gap_checks = 0, max_gap = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tas_lock_agent #(.MAX_DELAY(MAXD)) dut (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
    .owned(owned), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_lock(bus_lock),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // Zero-wait memory holding the lock word; the other agent acts via ext_set/ext_clr.
  assign mem_ready = mem_valid;
  assign mem_rdata = lock_word;

  always @(posedge clk) begin
    if (!rst_n) lock_word <= 1'b0;
    else if (mem_valid && mem_ready && mem_we) lock_word <= mem_wdata;
    else if (ext_set) lock_word <= 1'b1;
    else if (ext_clr) lock_word <= 1'b0;
  end

  // Arbiter: one-cycle grant latency, withheld while the other agent owns the bus.
  always @(negedge clk) begin
    if (!rst_n) bus_gnt = 1'b0;
    else bus_gnt = bus_req && !other_busy;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, sampled a quarter period after each rising edge.
  bit exp_owned = 0, expect_wr = 0, expect_drop = 0, pend = 0, req_prev = 0;
  int gap = 0, exp_delay = 1;

  always @(posedge clk) begin
    #5;
    if (!rst_n) begin
      exp_owned = 0; expect_wr = 0; expect_drop = 0; pend = 0; req_prev = 0;
      gap = 0; exp_delay = 1;
    end else begin
      check(owned == exp_owned, "R4/R9 owned", int'(owned), int'(exp_owned));
      if (mem_valid) begin
        acc_cnt++;
        check(bus_gnt, "R2 access without grant", int'(bus_gnt), 1);
      end
      if (bus_req && !req_prev) begin
        req_cnt++;
        if (pend) begin
          check(gap == exp_delay, "R6/R7 backoff gap", gap, exp_delay);
          gap_checks++;
          if (gap > max_gap) max_gap = gap;
          exp_delay = (exp_delay * 2 > MAXD) ? MAXD : exp_delay * 2;
          pend = 0;
        end
      end else if (pend && !bus_req) begin
        gap++;
      end
      req_prev = bus_req;
      if (expect_drop) begin
        check(!bus_lock, "R3 lock line held after write", int'(bus_lock), 0);
        expect_drop = 0;
      end
      if (expect_wr) begin
        check(mem_valid && mem_we && mem_wdata && bus_lock, "R3 locked write of 1",
              {mem_valid, mem_we, mem_wdata, bus_lock}, 4'b1111);
        expect_wr = 0;
      end
      if (mem_valid && !mem_we && mem_ready) begin
        check(bus_lock, "R3 read without lock line", int'(bus_lock), 1);
        expect_wr = 1;
      end
      if (mem_valid && mem_we && mem_wdata && mem_ready) begin
        expect_drop = 1;
        if (lock_word) begin
          fail_cnt++; pend = 1; gap = 0;   // R5 failed try, owned stays low
        end else begin
          exp_delay = 1;                   // R8
          exp_owned = 1;                   // R4
        end
      end
      if (mem_valid && mem_we && !mem_wdata && mem_ready) begin
        check(!bus_lock, "R9 release under lock line", int'(bus_lock), 0);
        exp_owned = 0;
      end
    end
  end

  task automatic pulse_acq();
    acq_req = 1'b1; @(negedge clk); acq_req = 1'b0;
  endtask
  task automatic pulse_rel();
    rel_req = 1'b1; @(negedge clk); rel_req = 1'b0;
  endtask

  initial begin
    int a0, r0;
    rst_n = 0; acq_req = 0; rel_req = 0; other_busy = 0; ext_set = 0; ext_clr = 0;
    repeat (3) @(negedge clk);
    check({owned, bus_req, bus_lock, mem_valid} == 4'b0, "R1 reset outputs",
          {owned, bus_req, bus_lock, mem_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check({owned, bus_req, bus_lock, mem_valid} == 4'b0, "R1 after reset",
          {owned, bus_req, bus_lock, mem_valid}, 0);

    // Free lock, late grant.
    other_busy = 1;
    pulse_acq();
    repeat (4) @(negedge clk);
    check(bus_req == 1'b1, "R2 request raised", int'(bus_req), 1);
    check(acc_cnt == 0, "R2 no access before grant", acc_cnt, 0);
    other_busy = 0;
    while (!owned) @(negedge clk);
    check(lock_word == 1'b1, "R4 lock word set", int'(lock_word), 1);
    check(fail_cnt == 0, "R4 first try wins", fail_cnt, 0);

    // Acquire while owning is ignored.
    a0 = acc_cnt; r0 = req_cnt;
    pulse_acq();
    repeat (6) @(negedge clk);
    check(acc_cnt == a0 && req_cnt == r0, "R10 acquire while owned", acc_cnt - a0, 0);
    check(owned == 1'b1, "R10 still owned", int'(owned), 1);

    // Release.
    pulse_rel();
    while (owned) @(negedge clk);
    check(lock_word == 1'b0, "R9 lock word cleared", int'(lock_word), 0);

    // Release while not owning is ignored.
    a0 = acc_cnt; r0 = req_cnt;
    pulse_rel();
    repeat (6) @(negedge clk);
    check(acc_cnt == a0 && req_cnt == r0, "R10 release while idle", acc_cnt - a0, 0);
    check(owned == 1'b0 && lock_word == 1'b0, "R10 state unchanged",
          {owned, lock_word}, 0);

    // Lock held by the other agent: doubling delays up to the ceiling.
    ext_set = 1; @(negedge clk); ext_set = 0;
    pulse_acq();
    while (fail_cnt < 7) @(negedge clk);
    check(owned == 1'b0, "R5 not owned after failures", int'(owned), 0);
    while (bus_req) @(negedge clk);
    ext_clr = 1; @(negedge clk); ext_clr = 0;
    while (!owned) @(negedge clk);
    check(gap_checks == 7, "R6 retries measured", gap_checks, 7);
    check(max_gap == MAXD, "R7 delay ceiling", max_gap, MAXD);
    pulse_rel();
    while (owned) @(negedge clk);

    // Delay restarts at one after a success.
    r0 = gap_checks;
    ext_set = 1; @(negedge clk); ext_set = 0;
    pulse_acq();
    while (gap_checks < r0 + 2) @(negedge clk);
    check(fail_cnt >= 9, "R8 failures seen again", fail_cnt, 9);
    while (bus_req) @(negedge clk);
    ext_clr = 1; @(negedge clk); ext_clr = 0;
    while (!owned) @(negedge clk);
    pulse_rel();
    while (owned) @(negedge clk);
    check(lock_word == 1'b0, "R9 final release", int'(lock_word), 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule